// File: doc/BRIEF.md
# Interrupt Enable Bank with Set and Clear Aliases

This block keeps a small bank of interrupt enable registers that software reaches over a plain memory-mapped bus with a 32-bit address. A register can be given a set address, a clear address, or both. When both exist, software can turn bits on or off without a read-modify-write. When only one exists, the written word replaces the stored value. Each register is cut into fields of a per-register width, and each field governs one interrupt source. Fields one bit wide act as enable bits. Wider fields hold a priority level, where zero means the source is off.

On every accepted write the bank compares each field before and after the update. For each field whose value moved, it emits one event on a per-source vector: an enable pulse when the new value is non-zero, or a disable pulse when it became zero. Fields that did not change emit nothing. Downstream pending and arbitration logic uses these pulses to keep per-source enable state. The bus has no handshake: a write is taken in every cycle that `bus_wr` is high, and no back-pressure exists. Read data is combinational on the address.

Top module: `ibank_mask_bank`

## Requirements
- R1: Address matching uses only bits 28:0 of `bus_addr`, so addresses that differ only in bits 31:29 reach the same register. A configured address of zero means "absent".
- R2: On a register that has both addresses, a write to the set address stores the old value OR the written data.
- R3: On a register that has both addresses, a write to the clear address stores the old value AND NOT the written data.
- R4: On a register that has only a set address, a write stores the data unchanged.
- R5: On a register that has only a clear address, a write stores the data unchanged. It does not clear the bits it names.
- R6: A register of width W with field width F has W/F fields. Field k sits at bit (W/F-1-k)*F and drives source SRC_BASE+k, so the first source takes the most significant field.
- R7: When a written field changes to a non-zero value, bit SRC_BASE+k of `src_enable` is high in the same cycle as the write, and only in that cycle.
- R8: When a written field changes to zero, bit SRC_BASE+k of `src_disable` is high in the same cycle as the write. A source never sees enable and disable together.
- R9: A field whose value is unchanged by a write produces no event, and a register that is not written keeps its value.
- R10: A write to an address that matches no register changes no register and produces no event. Reading such an address returns zero.
- R11: `bus_rdata` returns the stored value of the register matched by either of its addresses.
- R12: After reset all registers read zero and no event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, accepted every cycle it is high |
| bus_addr | input | 32 | Byte address for reads and writes |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Value of the addressed register, zero if none matches |
| src_enable | output | NUM_SRC | One-cycle enable event per source |
| src_disable | output | NUM_SRC | One-cycle disable event per source |

## Verification
The bench uses the default build: three 16-bit registers and 22 sources. The first register has both addresses and 1-bit fields. The second has only a set address and 4-bit priority fields. The third has only a clear address and 8-bit fields. This covers every write mode and shows the most-significant-first field order at three field widths. It also lets a priority field move between two non-zero levels, which must produce a fresh enable. Addresses that differ only in the top three bits test aliasing. A neighbouring unmapped word and address zero test the ignore rule.

// File: rtl/ibank_pkg.sv
package ibank_pkg;

  typedef enum logic [1:0] {
    WM_NONE   = 2'd0,
    WM_OR     = 2'd1,
    WM_ANDN   = 2'd2,
    WM_DIRECT = 2'd3
  } wmode_e;

  localparam int unsigned MATCH_BITS = 29;

  // An address of zero marks an absent alias.
  function automatic logic alias_hit(input logic [MATCH_BITS-1:0] a,
                                     input logic [31:0] cfg);
    return (cfg != 32'd0) && (a == cfg[MATCH_BITS-1:0]);
  endfunction

endpackage

// File: rtl/ibank_decode.sv
module ibank_decode
  import ibank_pkg::*;
#(
  parameter logic [31:0] SET_A = 32'd0,
  parameter logic [31:0] CLR_A = 32'd0
) (
  input  logic [MATCH_BITS-1:0] addr_low,
  output wmode_e                mode
);
  localparam bit HAS_SET = (SET_A != 32'd0);
  localparam bit HAS_CLR = (CLR_A != 32'd0);

  logic set_hit, clr_hit;
  assign set_hit = alias_hit(addr_low, SET_A);
  assign clr_hit = alias_hit(addr_low, CLR_A);

  generate
    if (HAS_SET && HAS_CLR) begin : g_dual
      always_comb begin
        if (set_hit)      mode = WM_OR;
        else if (clr_hit) mode = WM_ANDN;
        else              mode = WM_NONE;
      end
    end else begin : g_single
      always_comb mode = (set_hit || clr_hit) ? WM_DIRECT : WM_NONE;
    end
  endgenerate
endmodule

// File: rtl/ibank_reg.sv
module ibank_reg
  import ibank_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  wmode_e           mode,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q,
  output logic [REG_W-1:0] nxt,
  output logic             commit
);
  assign commit = wr && (mode != WM_NONE);

  always_comb begin
    unique case (mode)
      WM_OR:     nxt = q | wdata;
      WM_ANDN:   nxt = q & ~wdata;
      WM_DIRECT: nxt = wdata;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (commit) q <= nxt;
  end

  // R2: a set write only adds bits
  a_r2_set_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == WM_OR) |=> ((q & $past(q)) == $past(q)) && ((q & $past(wdata)) == $past(wdata)));
  // R3: a clear write removes the named bits
  a_r3_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == WM_ANDN) |=> ((q & $past(wdata)) == '0) && ((q | $past(q)) == $past(q)));
  // R4 and R5: single-address registers take the data as written
  a_r4_direct_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == WM_DIRECT) |=> (q == $past(wdata)));
  // R9: no write, no change
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && mode != WM_NONE) |=> $stable(q));
endmodule

// File: rtl/ibank_fields.sv
module ibank_fields #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned FIELD_W = 1,
  localparam int unsigned NF     = REG_W / FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [REG_W-1:0] old_v,
  input  logic [REG_W-1:0] new_v,
  output logic [NF-1:0]    en,
  output logic [NF-1:0]    dis
);
  generate
    for (genvar k = 0; k < NF; k++) begin : g_fld
      localparam int unsigned LSB = (NF - 1 - k) * FIELD_W;
      logic [FIELD_W-1:0] was, now;
      logic               moved;
      assign was   = old_v[LSB +: FIELD_W];
      assign now   = new_v[LSB +: FIELD_W];
      assign moved = commit && (was != now);
      assign en[k]  = moved && (now != '0);
      assign dis[k] = moved && (now == '0);
    end
  endgenerate

  // R8: one field never reports both directions
  a_r8_no_dual_event: assert property (@(posedge clk) disable iff (!rst_n)
    (en & dis) == '0);
  // R7: events only accompany a committed write
  a_r7_event_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ((en | dis) != '0) |-> commit);
endmodule

// File: rtl/ibank_mask_bank.sv
module ibank_mask_bank
  import ibank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned NUM_SRC  = 22,
  parameter logic [NUM_REGS-1:0][31:0] SET_ADDR =
    {32'h0000_0000, 32'hA400_0010, 32'hA400_0040},
  parameter logic [NUM_REGS-1:0][31:0] CLR_ADDR =
    {32'hA400_0020, 32'h0000_0000, 32'hA400_0060},
  parameter logic [NUM_REGS-1:0][7:0]  FIELD_W  =
    {8'd8, 8'd4, 8'd1},
  parameter logic [NUM_REGS-1:0][15:0] SRC_BASE =
    {16'd20, 16'd16, 16'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [31:0]        bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [NUM_SRC-1:0] src_enable,
  output logic [NUM_SRC-1:0] src_disable
);
  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[31:MATCH_BITS];

  logic [NUM_REGS-1:0][REG_W-1:0]   q_all;
  logic [NUM_REGS-1:0]              hit_all;
  logic [NUM_REGS-1:0][NUM_SRC-1:0] en_all, dis_all;

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam int unsigned FW   = int'(FIELD_W[r]);
      localparam int unsigned NF   = REG_W / FW;
      localparam int unsigned BASE = int'(SRC_BASE[r]);

      wmode_e            mode;
      logic [REG_W-1:0]  q, nxt;
      logic              commit;
      logic [NF-1:0]     f_en, f_dis;

      ibank_decode #(.SET_A(SET_ADDR[r]), .CLR_A(CLR_ADDR[r])) u_dec (
        .addr_low (bus_addr[MATCH_BITS-1:0]),
        .mode     (mode)
      );

      ibank_reg #(.REG_W(REG_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .mode   (mode),
        .wdata  (bus_wdata),
        .q      (q),
        .nxt    (nxt),
        .commit (commit)
      );

      ibank_fields #(.REG_W(REG_W), .FIELD_W(FW)) u_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .old_v  (q),
        .new_v  (nxt),
        .en     (f_en),
        .dis    (f_dis)
      );

      assign q_all[r]   = q;
      assign hit_all[r] = (mode != WM_NONE);

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        if (s >= BASE && s < BASE + NF) begin : g_on
          assign en_all[r][s]  = f_en[s - BASE];
          assign dis_all[r][s] = f_dis[s - BASE];
        end else begin : g_off
          assign en_all[r][s]  = 1'b0;
          assign dis_all[r][s] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    src_enable  = '0;
    src_disable = '0;
    bus_rdata   = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      src_enable  = src_enable  | en_all[r];
      src_disable = src_disable | dis_all[r];
      if (hit_all[r]) bus_rdata = bus_rdata | q_all[r];
    end
  end

  // R10: events appear only with a write strobe
  a_r10_events_need_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_enable | src_disable) != '0) |-> bus_wr);
  // R10: an unmatched address reads zero
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_all == '0) |-> (bus_rdata == '0));
  // R8: a source never gets both pulses
  a_r8_src_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (src_enable & src_disable) == '0);
endmodule

// File: tb/ibank_mask_bank_tb.sv
module ibank_mask_bank_tb;
  localparam int REG_W = 16;
  localparam int NSRC  = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [31:0]      bus_addr = '0;
  logic [REG_W-1:0] bus_wdata = '0;
  logic [REG_W-1:0] bus_rdata;
  logic [NSRC-1:0]  src_enable, src_disable;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ibank_mask_bank u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .src_enable  (src_enable),
    .src_disable (src_disable)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one write; events are checked inside the write cycle, then again after it.
  task automatic do_write(input logic [31:0] a, input logic [REG_W-1:0] d,
                          input logic [NSRC-1:0] exp_en, input logic [NSRC-1:0] exp_dis,
                          input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #2;
    check(req, "enable events", 32'(src_enable), 32'(exp_en));
    check(req, "disable events", 32'(src_disable), 32'(exp_dis));
    @(posedge clk);
    #1 bus_wr = 1'b0;
    #2;
    check("R7", "events after write", 32'(src_enable | src_disable), 32'd0);
  endtask

  task automatic do_read(input logic [31:0] a, input logic [REG_W-1:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #2 check(req, "read data", 32'(bus_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    do_read(32'hA400_0040, '0, "R12");
    do_read(32'hA400_0010, '0, "R12");
    do_read(32'hA400_0020, '0, "R12");
    check("R12", "idle events", 32'(src_enable | src_disable), 32'd0);
  endtask

  task automatic t_dual_set;
    do_write(32'hA400_0040, 16'h8001, 22'h008001, '0, "R2 R6 R7");
    do_read (32'hA400_0040, 16'h8001, "R2");
    do_write(32'hA400_0040, 16'h8002, 22'h004000, '0, "R2 R9");
    do_read (32'hA400_0040, 16'h8003, "R2");
  endtask

  task automatic t_dual_clear;
    do_write(32'h0400_0060, 16'h8000, '0, 22'h000001, "R1 R3 R8");
    do_read (32'hE400_0040, 16'h0003, "R1 R11");
    do_write(32'hA400_0060, 16'h0100, '0, '0, "R3 R9");
    do_read (32'hA400_0060, 16'h0003, "R11");
  endtask

  task automatic t_set_only_prio;
    do_write(32'hA400_0010, 16'h3050, 22'h050000, '0, "R4 R6");
    do_read (32'hA400_0010, 16'h3050, "R4");
    do_write(32'hA400_0010, 16'h3000, '0, 22'h040000, "R8");
    do_write(32'hA400_0010, 16'h1000, 22'h010000, '0, "R7");
    do_write(32'h2400_0010, 16'h1000, '0, '0, "R9 R1");
    do_read (32'hA400_0010, 16'h1000, "R4");
  endtask

  task automatic t_clear_only;
    do_write(32'hA400_0020, 16'h00AB, 22'h200000, '0, "R5 R6");
    do_read (32'hA400_0020, 16'h00AB, "R5");
    do_write(32'hA400_0020, 16'hAB00, 22'h100000, 22'h200000, "R5 R7 R8");
    do_read (32'hA400_0020, 16'hAB00, "R5");
  endtask

  task automatic t_unmapped;
    do_write(32'hA400_0044, 16'hFFFF, '0, '0, "R10");
    do_write(32'h0000_0000, 16'hFFFF, '0, '0, "R10");
    do_read (32'hA400_0044, '0, "R10");
    do_read (32'hA400_0040, 16'h0003, "R10");
    do_read (32'hA400_0010, 16'h1000, "R10");
    do_read (32'hA400_0020, 16'hAB00, "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_dual_set();
    t_dual_clear();
    t_set_only_prio();
    t_clear_only();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule